// File: doc/BRIEF.md
# Post-Sync Symbol Accumulator

After a tracking channel has found its bit or secondary-code boundary, this block turns the stream of per-period prompt correlations into decoded data bits. Every prompt sample presented with its strobe while sync is held is added into a signed running sum, and a counter tracks how many primary periods of the current symbol have been integrated. When that count reaches the configured periods-per-symbol value, the sign of the sum gives a hard decision, corrected for the polarity the sync detector locked at, and the bit is shifted into a 128-bit history. The sum and counter then restart for the next symbol.

The periods-per-symbol input sets the cadence: 20 for a 50 Hz data signal with a 1 ms primary code, 10 for a signal with a ten-chip overlay code, 1 for signals that carry one symbol per block, and 0 for a pilot with no data, in which case the block does nothing. A soft clear empties the bit history but keeps the counter and the partial sum, so the symbol cadence survives without a new sync search.

Top module: `sym_accum`

## Requirements
- R1: While found_i is low, samples change neither blk_cnt_o nor bits_o, and bit_valid_o stays low.
- R2: Each cycle with found_i, prompt_valid_i high and bps_i nonzero adds prompt_i into the sum and, unless the symbol completes, raises blk_cnt_o by one on the following cycle.
- R3: The sample that brings the integrated count to bps_i completes the symbol: on the next cycle bit_valid_o is high for one cycle, blk_cnt_o is 0 and the sum restarts from zero. bit_valid_o is never high otherwise.
- R4: The raw decision is 1 when the completed sum is zero or positive and 0 when it is negative.
- R5: With neg_pol_i high (locked at negative polarity) the raw decision is inverted before it is stored.
- R6: Each committed bit enters bits_o[0] while older bits move one place toward bit 127; the oldest bit is dropped after 128 commits.
- R7: A soft_clr_i pulse zeroes bits_o and leaves blk_cnt_o and the partial sum unchanged, so the next commit occurs on the original cadence with the original sum.
- R8: With bps_i equal to 0 (pilot, no data) samples are ignored: no counter change, no commit.
- R9: The sum holds 2^BPS_W-1 full-scale samples without overflow; 20 samples of -32768 decide 0.
- R10: Cycles with prompt_valid_i low change neither the sum nor blk_cnt_o.
- R11: After reset bits_o is 0, blk_cnt_o is 0 and bit_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Soft clear: empties history, keeps cadence |
| found_i | input | 1 | Sync has been declared |
| neg_pol_i | input | 1 | Sync locked at negative polarity |
| bps_i | input | BPS_W | Primary periods per symbol, 0 for pilot |
| prompt_valid_i | input | 1 | Prompt sample strobe |
| prompt_i | input | IN_W | Signed real part of the prompt |
| bits_o | output | 128 | Decoded bit history, newest in bit 0 |
| bit_valid_o | output | 1 | One-cycle pulse after each commit |
| blk_cnt_o | output | BPS_W | Periods integrated in the current symbol |

## Verification
The hardest case to reach is a soft clear landing in the middle of a symbol, since only a later commit shows whether the partial sum and count survived. The stimulus integrates three positive samples, pulses the clear, then supplies seven negative samples whose total flips the decision only if the earlier three were lost, and checks that the commit arrives on the tenth sample. Overflow is reached by summing twenty full-scale negative samples, whose total truncated to the input width would read as zero and decide the wrong bit.

// File: rtl/sym_acc_pkg.sv
package sym_acc_pkg;
  localparam int unsigned HIST_W = 128;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;
endpackage

// File: rtl/sym_cadence.sv
module sym_cadence #(
  parameter int unsigned BPS_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [BPS_W-1:0] bps_i,
  output logic [BPS_W-1:0] cnt_o,
  output logic             last_o
);
  logic [BPS_W-1:0] cnt_q;
  logic [BPS_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // >= so a lowered bps still closes the symbol
  assign last_o  = cnt_inc >= {1'b0, bps_i};
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_inc[BPS_W-1:0];
    end
  end
endmodule

// File: rtl/sym_acc_datapath.sv
module sym_acc_datapath
  import sym_acc_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned BPS_W = 6,
  localparam int unsigned ACC_W = IN_W + BPS_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   step_i,
  input  logic                   last_i,
  input  logic signed [IN_W-1:0] sample_i,
  input  logic                   neg_pol_i,
  output logic                   dec_bit_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] sample_ext;
  logic                    raw_bit;
  pol_e                    pol;

  assign sample_ext = {{BPS_W{sample_i[IN_W-1]}}, sample_i};
  assign sum        = acc_q + sample_ext;
  assign raw_bit    = ~sum[ACC_W-1];
  assign pol        = pol_e'(neg_pol_i);
  assign dec_bit_o  = (pol == POL_NEG) ? ~raw_bit : raw_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= last_i ? '0 : sum;
    end
  end
endmodule

// File: rtl/bit_history.sv
module bit_history #(
  parameter int unsigned HIST_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  assign hist_o = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      case ({clr_i, push_i})
        2'b11:   hist_q <= {{(HIST_W-1){1'b0}}, bit_i};
        2'b10:   hist_q <= '0;
        2'b01:   hist_q <= {hist_q[HIST_W-2:0], bit_i};
        default: hist_q <= hist_q;
      endcase
    end
  end
endmodule

// File: rtl/sym_accum.sv
module sym_accum
  import sym_acc_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned BPS_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   soft_clr_i,
  input  logic                   found_i,
  input  logic                   neg_pol_i,
  input  logic [BPS_W-1:0]       bps_i,
  input  logic                   prompt_valid_i,
  input  logic signed [IN_W-1:0] prompt_i,
  output logic [HIST_W-1:0]      bits_o,
  output logic                   bit_valid_o,
  output logic [BPS_W-1:0]       blk_cnt_o
);
  logic step;
  logic last;
  logic commit;
  logic dec_bit;
  logic bit_valid_q;

  // pilot (bps 0) never steps
  assign step   = found_i & prompt_valid_i & (bps_i != '0);
  assign commit = step & last;

  sym_cadence #(.BPS_W(BPS_W)) u_cad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .bps_i  (bps_i),
    .cnt_o  (blk_cnt_o),
    .last_o (last)
  );

  sym_acc_datapath #(.IN_W(IN_W), .BPS_W(BPS_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .last_i    (last),
    .sample_i  (prompt_i),
    .neg_pol_i (neg_pol_i),
    .dec_bit_o (dec_bit)
  );

  bit_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (commit),
    .bit_i  (dec_bit),
    .clr_i  (soft_clr_i),
    .hist_o (bits_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_valid_q <= 1'b0;
    else         bit_valid_q <= commit;
  end

  assign bit_valid_o = bit_valid_q;
endmodule

// File: rtl/sym_accum_checker.sv
module sym_accum_checker #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned BPS_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   soft_clr_i,
  input logic                   found_i,
  input logic                   neg_pol_i,
  input logic [BPS_W-1:0]       bps_i,
  input logic                   prompt_valid_i,
  input logic signed [IN_W-1:0] prompt_i,
  input logic [127:0]           bits_o,
  input logic                   bit_valid_o,
  input logic [BPS_W-1:0]       blk_cnt_o
);
  logic active;
  logic closes;

  assign active = found_i && prompt_valid_i && (bps_i != '0);
  assign closes = ({1'b0, blk_cnt_o} + 1'b1) >= {1'b0, bps_i};

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!found_i && !soft_clr_i) |=> ($stable(blk_cnt_o) && $stable(bits_o) && !bit_valid_o));

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !closes) |=> (blk_cnt_o == $past(blk_cnt_o) + 1'b1) && !bit_valid_o);

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && closes) |=> (bit_valid_o && blk_cnt_o == '0));

  p_pulse_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active && closes) |=> !bit_valid_o);

  p_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !$past(soft_clr_i)) |-> (bits_o[127:1] == $past(bits_o[126:0])));

  p_soft_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (bits_o[127:1] == '0));

  p_soft_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_clr_i && !active) |=> $stable(blk_cnt_o));

  p_pilot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bps_i == '0 && !soft_clr_i) |=> ($stable(blk_cnt_o) && $stable(bits_o) && !bit_valid_o));

  p_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prompt_valid_i |=> ($stable(blk_cnt_o) && !bit_valid_o));
endmodule

bind sym_accum sym_accum_checker #(.IN_W(IN_W), .BPS_W(BPS_W)) u_chk (.*);

// File: tb/sym_accum_test.sv
`timescale 1ns/1ps
module sym_accum_test;
  localparam int IN_W  = 16;
  localparam int BPS_W = 6;

  typedef struct packed {
    logic [BPS_W-1:0]       bps;
    logic                   pol;
    logic signed [IN_W-1:0] s0;
    logic signed [IN_W-1:0] s1;
    logic                   exp;
  } vec_t;

  // first sample s0, then s1 for the rest of the symbol
  localparam vec_t VECS [10] = '{
    '{6'd20, 1'b0,  16'sd100,   -16'sd5,    1'b1},  // R4 +5
    '{6'd20, 1'b0,  16'sd100,   -16'sd6,    1'b0},  // R4 -14
    '{6'd10, 1'b0, -16'sd50,     16'sd5,    1'b0},  // R4 -5
    '{6'd10, 1'b1, -16'sd50,     16'sd5,    1'b1},  // R5
    '{6'd1,  1'b0,  16'sd0,      16'sd0,    1'b1},  // R4 zero
    '{6'd1,  1'b1,  16'sd0,      16'sd0,    1'b0},  // R5
    '{6'd1,  1'b0, -16'sd1,      16'sd0,    1'b0},  // R4
    '{6'd20, 1'b0, -16'sd32768, -16'sd32768, 1'b0}, // R9
    '{6'd20, 1'b1,  16'sd32767,  16'sd32767, 1'b0}, // R9 R5
    '{6'd10, 1'b0, -16'sd45,     16'sd5,    1'b1}   // R4 sum 0
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   soft_clr_i = 1'b0;
  logic                   found_i = 1'b0;
  logic                   neg_pol_i = 1'b0;
  logic [BPS_W-1:0]       bps_i = '0;
  logic                   prompt_valid_i = 1'b0;
  logic signed [IN_W-1:0] prompt_i = '0;
  logic [127:0]           bits_o;
  logic                   bit_valid_o;
  logic [BPS_W-1:0]       blk_cnt_o;

  int n_run = 0;
  int n_fail = 0;
  logic [127:0] exp_hist = '0;
  logic done = 1'b0;

  always #2 clk_i = ~clk_i;

  sym_accum #(.IN_W(IN_W), .BPS_W(BPS_W)) uut (.*);

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic signed [IN_W-1:0] s);
    @(negedge clk_i);
    prompt_valid_i = 1'b1;
    prompt_i = s;
    @(posedge clk_i);
    #1;
    prompt_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle(2);
    // R11 reset state
    check(bits_o == '0 && blk_cnt_o == '0 && !bit_valid_o, "R11 reset",
          {bits_o[126:0], bit_valid_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(1);

    // R1 no sync: nothing moves
    bps_i = 6'd1;
    for (int k = 0; k < 4; k++) push(16'sd7);
    check(blk_cnt_o == '0 && bits_o == '0 && !bit_valid_o, "R1 idle",
          {bits_o[126:0], bit_valid_o}, '0);

    // table walk
    found_i = 1'b1;
    foreach (VECS[v]) begin
      @(negedge clk_i);
      bps_i = VECS[v].bps;
      neg_pol_i = VECS[v].pol;
      for (int k = 0; k < int'(VECS[v].bps); k++) begin
        push(k == 0 ? VECS[v].s0 : VECS[v].s1);
        if (k < int'(VECS[v].bps) - 1)
          check(blk_cnt_o == BPS_W'(k + 1) && !bit_valid_o, "R2 count",
                128'(blk_cnt_o), 128'(k + 1));
      end
      exp_hist = {exp_hist[126:0], VECS[v].exp};
      check(bit_valid_o && blk_cnt_o == '0, "R3 commit",
            {blk_cnt_o, bit_valid_o}, 128'(1));
      check(bits_o == exp_hist, "R4 R5 R9 decision", bits_o, exp_hist);
      idle(1);
      check(!bit_valid_o, "R3 single pulse", 128'(bit_valid_o), '0);
    end

    // R10 strobe low holds count, R7 soft clear mid-symbol
    neg_pol_i = 1'b0;
    bps_i = 6'd10;
    for (int k = 0; k < 3; k++) push(16'sd10);
    idle(5);
    check(blk_cnt_o == 6'd3 && !bit_valid_o, "R10 hold", 128'(blk_cnt_o), 128'd3);
    @(negedge clk_i);
    soft_clr_i = 1'b1;
    @(negedge clk_i);
    soft_clr_i = 1'b0;
    #1;
    check(bits_o == '0, "R7 history cleared", bits_o, '0);
    check(blk_cnt_o == 6'd3, "R7 count kept", 128'(blk_cnt_o), 128'd3);
    for (int k = 0; k < 6; k++) push(-16'sd4);
    check(!bit_valid_o && blk_cnt_o == 6'd9, "R7 cadence", 128'(blk_cnt_o), 128'd9);
    push(-16'sd4);
    check(bit_valid_o && bits_o == 128'd1, "R7 sum kept", bits_o, 128'd1);
    exp_hist = 128'd1;

    // R8 pilot
    bps_i = '0;
    for (int k = 0; k < 5; k++) push(-16'sd100);
    check(!bit_valid_o && blk_cnt_o == '0 && bits_o == exp_hist, "R8 pilot",
          bits_o, exp_hist);

    // R6 depth: 130 single-block symbols
    bps_i = 6'd1;
    for (int k = 0; k < 130; k++) begin
      push((k % 3 == 0) ? -16'sd1 : 16'sd1);
      exp_hist = {exp_hist[126:0], (k % 3 != 0)};
    end
    check(bits_o == exp_hist, "R6 history depth", bits_o, exp_hist);

    done = 1'b1;
    finish_run();
  end
endmodule